// File: doc/BRIEF.md
# Protected Register Write Sequencer

This block keeps a small bank of control registers on a simple synchronous peripheral bus safe from stray writes. A protected register changes only when the bus access just before the write to it was a write to a dedicated command register. The value written to the command register does not matter. If any other access comes between the two, or if there was no command write at all, the protected write is dropped. A sticky protection-error bit in a status register then records the failure. Reads need no such sequence and always return the current contents.

The bus carries one access per cycle. An access is a write (`bus_wr`) or a read (`bus_rd`). If both are high, the access is a write. A write can be a plain store, or a single-bit set, clear or invert that is applied in the same access. Bit operations on protected registers follow the same unlock rule as stores.

The address map is:

| Address | Register |
|---|---|
| 0 | Command register |
| 1 | Status register |
| 2 to 2+NREG-1 | Protected registers |

Protected register 0, at address 2, is the mode control register for the programming engine. All other addresses are unmapped.

The unlock tracker is a two-state machine:

- `SEQ_LOCKED` (reset state): moves to `SEQ_ARMED` on a write to the command register.
- `SEQ_ARMED`: stays in `SEQ_ARMED` on a further command write. Any other read or write, at any address, sends it back to `SEQ_LOCKED`.

A cycle with no access leaves the state unchanged in both states.

Top module: `prot_wr_seq`

## Requirements
- R1: After reset, every protected register reads 0x00, `prot_err` is 0 and the tracker is in `SEQ_LOCKED`.
- R2: A write to address 0 arms the tracker whatever its data and operation. A command write while already armed keeps it armed.
- R3: A store to a protected register made while armed loads `bus_wdata`. The new value is visible after that clock edge. For example, 0x02 written to address 2 shows on `prot_q[7:0]`.
- R4: Any access that is not a command write disarms the tracker. This includes a read of any address, including the command register. A protected write that follows such an access is dropped and sets `prot_err`.
- R5: A protected write made while locked leaves the register unchanged and sets `prot_err` on the next edge.
- R6: A protected write consumes the unlock, so a second protected write straight after it is dropped and flags an error.
- R7: `bus_bitop` gives the write operation: 00 is a store of `bus_wdata`, 01 sets, 10 clears and 11 inverts the bit indexed by `bus_wdata[2:0]`. Bit operations on protected registers update only when armed, and are otherwise dropped with an error.
- R8: A read (`bus_rd`=1, `bus_wr`=0) returns data on `bus_rdata` in the same cycle, with no unlock needed. Reads give:
  - the current value for a protected register;
  - `{7'b0, prot_err}` for the status register;
  - 0x00 for the command register.

  `bus_rdata` is 0x00 when no read is made.
- R9: `prot_err` stays set until the status register is written with a result whose bit 0 is 0, through a store or a bit operation. Writing bit 0 as 1 never sets it. The status register is not protected.
- R10: Cycles with neither `bus_wr` nor `bus_rd` do not change the tracker, so an armed unlock survives idle cycles.
- R11: Writes to unmapped addresses change no register but count as an intervening access. Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (4) | Access address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_bitop | input | 2 | Write operation: store, set, clear or invert |
| bus_wdata | input | DW (8) | Write data, or the bit index in bits [2:0] |
| bus_rdata | output | DW (8) | Read data, combinational |
| prot_q | output | NREG*DW (32) | Protected register contents, register i at [i*DW +: DW] |
| prot_err | output | 1 | Sticky protection-error status bit |

## Verification
A tracker left wrongly armed shows up one edge after the next protected write: the register takes a value it should have refused and `prot_err` stays low. A tracker left wrongly locked shows the reverse, an unchanged register and a raised error. A fault in the bit-operation or read path shows at once on `bus_rdata` in the same cycle as the read, or on `prot_q` one edge after the write. The bench's reference model is compared on every clock, so each fault appears within one or two cycles of the access that exposes it.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [1:0] {
        BIT_STORE = 2'b00,
        BIT_SET   = 2'b01,
        BIT_CLR   = 2'b10,
        BIT_INV   = 2'b11
    } bitop_e;

    typedef enum logic {
        SEQ_LOCKED = 1'b0,
        SEQ_ARMED  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/prot_bitop.sv
module prot_bitop #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] old_val,
    input  logic [1:0]    op,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] new_val
);
    import prot_pkg::*;

    localparam int IDXW = (DW > 1) ? $clog2(DW) : 1;

    logic [IDXW-1:0] bit_idx;
    logic [DW-1:0]   mask;

    assign bit_idx = wdata[IDXW-1:0];
    assign mask    = DW'(1) << bit_idx;

    always_comb begin
        unique case (bitop_e'(op))
            BIT_STORE: new_val = wdata;
            BIT_SET:   new_val = old_val | mask;
            BIT_CLR:   new_val = old_val & ~mask;
            BIT_INV:   new_val = old_val ^ mask;
            default:   new_val = wdata;
        endcase
    end

endmodule

// File: rtl/prot_unlock_fsm.sv
module prot_unlock_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic cmd_wr,
    output logic armed
);
    import prot_pkg::*;

    seq_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_LOCKED: if (cmd_wr)            st_d = SEQ_ARMED;
            SEQ_ARMED:  if (access && !cmd_wr) st_d = SEQ_LOCKED;
            default:                           st_d = SEQ_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEQ_LOCKED;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            SEQ_ARMED: armed = 1'b1;
            default:   armed = 1'b0;
        endcase
    end

    a_r2_cmd_arms: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> armed);
    a_r4_access_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !cmd_wr) |=> !armed);
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !access |=> $stable(armed));

endmodule

// File: rtl/prot_reg_bank.sv
module prot_reg_bank #(
    parameter int DW   = 8,
    parameter int NREG = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          wr_sel,
    input  logic                     armed,
    input  logic [DW-1:0]            new_val,
    output logic [NREG-1:0][DW-1:0]  q,
    output logic                     drop
);

    assign drop = (|wr_sel) && !armed;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                  q[i] <= '0;
            else if (wr_sel[i] && armed) q[i] <= new_val;
        end

        a_r5_locked_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel[i] && !armed) |=> $stable(q[i]));
        a_r3_armed_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel[i] && armed) |=> (q[i] == $past(new_val)));
        a_r11_unselected_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_sel[i] |=> $stable(q[i]));
    end

endmodule

// File: rtl/prot_status.sv
module prot_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_err,
    input  logic stat_wr,
    input  logic stat_bit0,
    output logic err
);

    always_ff @(posedge clk) begin
        if (!rst_n)                     err <= 1'b0;
        else if (set_err)               err <= 1'b1;
        else if (stat_wr && !stat_bit0) err <= 1'b0;
    end

    a_r5_error_raised: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> err);
    a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !stat_wr) |=> err);
    a_r9_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && !set_err) |=> !err);

endmodule

// File: rtl/prot_wr_seq.sv
module prot_wr_seq #(
    parameter int AW        = 4,
    parameter int DW        = 8,
    parameter int NREG      = 4,
    parameter int CMD_ADDR  = 0,
    parameter int STAT_ADDR = 1,
    parameter int PROT_BASE = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [1:0]           bus_bitop,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic [NREG*DW-1:0]   prot_q,
    output logic                 prot_err
);

    localparam int IW        = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int PROT_LAST = PROT_BASE + NREG - 1;
    localparam logic [AW-1:0] PROT_A = AW'(PROT_BASE);

    logic                    access, rd_only;
    logic                    cmd_hit, stat_hit, prot_hit;
    logic                    cmd_wr, stat_wr, prot_wr;
    logic [IW-1:0]           idx;
    logic [NREG-1:0]         wr_sel;
    logic [DW-1:0]           old_val, new_val, stat_val;
    logic                    armed, drop;
    logic [NREG-1:0][DW-1:0] q;

    assign access   = bus_wr | bus_rd;
    assign rd_only  = bus_rd & ~bus_wr;
    assign cmd_hit  = (int'(bus_addr) == CMD_ADDR);
    assign stat_hit = (int'(bus_addr) == STAT_ADDR);
    assign prot_hit = (int'(bus_addr) >= PROT_BASE) && (int'(bus_addr) <= PROT_LAST);
    assign cmd_wr   = bus_wr & cmd_hit;
    assign stat_wr  = bus_wr & stat_hit;
    assign prot_wr  = bus_wr & prot_hit;
    assign idx      = IW'(bus_addr - PROT_A);
    assign wr_sel   = prot_wr ? (NREG'(1) << idx) : '0;
    assign stat_val = {{(DW-1){1'b0}}, prot_err};

    always_comb begin
        if (stat_hit)      old_val = stat_val;
        else if (prot_hit) old_val = q[idx];
        else               old_val = '0;
    end

    always_comb begin
        if (!rd_only)      bus_rdata = '0;
        else if (stat_hit) bus_rdata = stat_val;
        else if (prot_hit) bus_rdata = q[idx];
        else               bus_rdata = '0;
    end

    prot_bitop #(.DW(DW)) u_bitop (
        .old_val (old_val),
        .op      (bus_bitop),
        .wdata   (bus_wdata),
        .new_val (new_val)
    );

    prot_unlock_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .access (access),
        .cmd_wr (cmd_wr),
        .armed  (armed)
    );

    prot_reg_bank #(.DW(DW), .NREG(NREG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .armed   (armed),
        .new_val (new_val),
        .q       (q),
        .drop    (drop)
    );

    prot_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_err   (drop),
        .stat_wr   (stat_wr),
        .stat_bit0 (new_val[0]),
        .err       (prot_err)
    );

    assign prot_q = q;

    a_r8_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && cmd_hit) |-> (bus_rdata == '0));
    a_r6_unlock_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr |=> !armed);

endmodule

// File: tb/sim_prot_wr_seq.sv
module sim_prot_wr_seq;

    localparam int AW = 4, DW = 8, NREG = 4;
    localparam int CMD = 0, STAT = 1, BASE = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [AW-1:0]     bus_addr;
    logic              bus_wr, bus_rd;
    logic [1:0]        bus_bitop;
    logic [DW-1:0]     bus_wdata;
    logic [DW-1:0]     bus_rdata;
    logic [NREG*DW-1:0] prot_q;
    logic              prot_err;

    always #5 clk = ~clk;

    prot_wr_seq u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_bitop(bus_bitop), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .prot_q(prot_q), .prot_err(prot_err)
    );

    int    checks = 0, fails = 0;
    string cur = "R1";
    int    m_reg [NREG];
    int    m_err, m_arm;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int apply_op(int old, int op, int wd);
        int m = 1 << (wd & 7);
        case (op)
            0:       return wd & 255;
            1:       return (old | m) & 255;
            2:       return (old & ~m) & 255;
            default: return (old ^ m) & 255;
        endcase
    endfunction

    function automatic int read_exp(int a);
        if (a == STAT) return m_err;
        if (a >= BASE && a < BASE + NREG) return m_reg[a - BASE];
        return 0;
    endfunction

    task automatic compare_all();
        for (int i = 0; i < NREG; i++) chk(cur, prot_q[i*DW +: DW], m_reg[i]);
        chk(cur, prot_err, m_err);
    endtask

    task automatic cyc(int a, bit wr, bit rd, int op, int wd);
        int nv, arm_n;
        @(negedge clk);
        bus_addr = AW'(a); bus_wr = wr; bus_rd = rd;
        bus_bitop = 2'(op); bus_wdata = DW'(wd);
        #2;
        if (rd && !wr) chk({cur, "/R8 read"}, bus_rdata, read_exp(a));
        else           chk({cur, "/R8 idle rdata"}, bus_rdata, 0);
        arm_n = (wr && a == CMD) ? 1 : ((wr || rd) ? 0 : m_arm);
        if (wr) begin
            if (a == STAT) begin
                nv = apply_op(m_err, op, wd);
                if ((nv & 1) == 0) m_err = 0;
            end else if (a >= BASE && a < BASE + NREG) begin
                if (m_arm == 1) m_reg[a - BASE] = apply_op(m_reg[a - BASE], op, wd);
                else            m_err = 1;
            end
        end
        m_arm = arm_n;
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_bitop = 0; bus_wdata = 0;
        for (int i = 0; i < NREG; i++) m_reg[i] = 0;
        m_err = 0; m_arm = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        cur = "R1"; #1; compare_all();
        cyc(STAT, 0, 1, 0, 0);
        // R2 and R3: unlock then store 0x02 to mode control register
        cur = "R3"; cyc(CMD, 1, 0, 0, 8'hA5); cyc(BASE, 1, 0, 0, 8'h02);
        chk("R3 mode reg", prot_q[7:0], 8'h02);
        cur = "R8"; cyc(BASE, 0, 1, 0, 0); cyc(CMD, 0, 1, 0, 0);
        // R2: repeated command write keeps the unlock
        cur = "R2"; cyc(CMD, 1, 0, 3, 8'hFF); cyc(CMD, 1, 0, 0, 8'h00); cyc(BASE+1, 1, 0, 0, 8'h3C);
        chk("R2 rearm", prot_q[15:8], 8'h3C);
        // R10: idle cycles keep the unlock
        cur = "R10"; cyc(CMD, 1, 0, 0, 0); idle(); idle(); idle(); cyc(BASE+1, 1, 0, 0, 8'h5C);
        chk("R10 idle kept unlock", prot_q[15:8], 8'h5C);
        // R6: unlock consumed by one write
        cur = "R6"; cyc(CMD, 1, 0, 0, 0); cyc(BASE+2, 1, 0, 0, 8'h11); cyc(BASE+2, 1, 0, 0, 8'h22);
        chk("R6 second dropped", prot_q[23:16], 8'h11); chk("R6 err", prot_err, 1);
        // R9: sticky, write 1 keeps, write 0 clears
        cur = "R9"; idle(); idle(); cyc(STAT, 1, 0, 0, 8'h01); chk("R9 kept", prot_err, 1);
        cyc(STAT, 1, 0, 0, 8'h00); chk("R9 cleared", prot_err, 0);
        cyc(STAT, 1, 0, 0, 8'h01); chk("R9 no soft set", prot_err, 0);
        // R4: intervening read of a protected register
        cur = "R4"; cyc(CMD, 1, 0, 0, 0); cyc(BASE, 0, 1, 0, 0); cyc(BASE+3, 1, 0, 0, 8'h77);
        chk("R4 read breaks", prot_q[31:24], 0); chk("R4 err", prot_err, 1);
        cyc(STAT, 1, 0, 0, 0);
        cyc(CMD, 1, 0, 0, 0); cyc(CMD, 0, 1, 0, 0); cyc(BASE+3, 1, 0, 0, 8'h78);
        chk("R4 cmd read breaks", prot_q[31:24], 0);
        cyc(STAT, 1, 0, 2, 0);
        chk("R9 clear by bit op", prot_err, 0);
        // R11: unmapped write breaks, unmapped read is zero
        cur = "R11"; cyc(CMD, 1, 0, 0, 0); cyc(15, 1, 0, 0, 8'hEE); cyc(BASE+3, 1, 0, 0, 8'h79);
        chk("R11 unmapped breaks", prot_q[31:24], 0);
        cyc(15, 0, 1, 0, 0); cyc(STAT, 1, 0, 0, 0);
        // R5: write with no unlock at all
        cur = "R5"; cyc(BASE+1, 1, 0, 0, 8'h99);
        chk("R5 dropped", prot_q[15:8], 8'h5C); chk("R5 err", prot_err, 1);
        cyc(STAT, 1, 0, 0, 0);
        // R7: bit operations
        cur = "R7"; cyc(CMD, 1, 0, 0, 0); cyc(BASE, 1, 0, 1, 7);
        chk("R7 set", prot_q[7:0], 8'h82);
        cyc(CMD, 1, 0, 0, 0); cyc(BASE, 1, 0, 2, 1); chk("R7 clear", prot_q[7:0], 8'h80);
        cyc(CMD, 1, 0, 0, 0); cyc(BASE, 1, 0, 3, 0); chk("R7 invert", prot_q[7:0], 8'h81);
        cyc(BASE, 1, 0, 3, 0); chk("R7 locked invert dropped", prot_q[7:0], 8'h81);
        chk("R7 err", prot_err, 1);
        cyc(BASE, 1, 1, 1, 3);
        idle();
        finish_run();
    end

endmodule